// File: doc/BRIEF.md
# Virtual-Channel Router Input Port

This block is the receiving side of one router port in an on-chip network. A single physical link delivers at most one flit per cycle. Each flit carries a two-bit type and a virtual-channel number. The port files every flit into the queue owned by that virtual channel. Each queue is a small FIFO with its own pointers and occupancy. Each virtual channel therefore holds its own stream of packets, and a stalled packet on one channel never holds up traffic on another.

The port also follows packet framing on each channel. A head flit opens a packet and a tail flit closes it. Because route information travels only in the head flit, this framing state tells later router stages which queue fronts begin a packet.

Every queue presents its oldest flit to the downstream consumer, which can pop any subset of channels in the same cycle. Each pop sends a one-cycle credit back upstream on the freed channel. Two misbehaviours of the upstream sender are caught and latched per channel: a write into a full queue, and a body or tail flit that arrives with no packet open.

Top module: `vc_input_port`

## Requirements
- R1: A flit written with `in_vc` = v enters queue v only. It appears at queue v's output in the cycle after the write edge when that queue was empty, and queue v delivers flits in arrival order.
- R2: Flit types are encoded as 00 body, 01 head, 10 tail, 11 single-flit packet. An accepted head flit sets `vc_active[v]`. An accepted tail or single-flit packet clears it. A body flit leaves it unchanged.
- R3: An accepted body (00) or tail (10) flit on a channel whose `vc_active` bit is low sets `proto_err[v]`. This flag stays set until reset, and the flit is still stored.
- R4: A write to a queue that already holds DEPTH flits is discarded, even if that queue is popped in the same cycle. The write sets the sticky `overflow[v]` and leaves the queue contents and `vc_active[v]` unchanged.
- R5: Popping one channel, or writing to it, does not change the output flit, valid bit or occupancy of any other channel. Several channels may be popped in the same cycle.
- R6: A pop of a non-empty queue raises `credit[v]` for exactly the one cycle that follows the pop edge.
- R7: Asserting `deq[v]` while queue v is empty has no effect and produces no credit.
- R8: After reset every queue is empty, every channel is idle, and all flags and credits are low.
- R9: While `out_valid[v]` is high and `deq[v]` is low, the presented flit on channel v stays unchanged.
- R10: A write and a pop on the same non-full queue in one cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Link flit present this cycle |
| in_vc | input | VC_W | Virtual channel of the incoming flit |
| in_type | input | 2 | Flit type (00 body, 01 head, 10 tail, 11 single) |
| in_data | input | DATA_W | Flit payload |
| deq | input | NUM_VC | Per-channel pop request |
| out_valid | output | NUM_VC | Per-channel queue non-empty |
| out_type | output | 2*NUM_VC | Per-channel front flit type |
| out_data | output | DATA_W*NUM_VC | Per-channel front flit payload |
| vc_active | output | NUM_VC | Per-channel packet open |
| credit | output | NUM_VC | Per-channel one-cycle credit return |
| overflow | output | NUM_VC | Sticky write-to-full flag |
| proto_err | output | NUM_VC | Sticky framing error flag |

## Verification
The hardest case to reach is a queue that is full when a write arrives and is popped in that same cycle, while the other channel is busy too. A credit-respecting sender never produces this. The stimulus reaches it on purpose: it fills channel 0 to depth, then issues a write together with a pop, and meanwhile pops and refills channel 1. Every ordered pair of flit types is applied to each channel from the idle state, so every framing transition and error condition is reached. A long pseudo-random run then mixes all of these cases, and a bench-side queue model checks every port each cycle.

// File: rtl/vc_input_port.sv
module vc_input_port #(
  parameter int NUM_VC = 2,
  parameter int DEPTH  = 3,
  parameter int DATA_W = 16,
  localparam int VC_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [VC_W-1:0]          in_vc,
  input  logic [1:0]               in_type,
  input  logic [DATA_W-1:0]        in_data,
  input  logic [NUM_VC-1:0]        deq,
  output logic [NUM_VC-1:0]        out_valid,
  output logic [2*NUM_VC-1:0]      out_type,
  output logic [DATA_W*NUM_VC-1:0] out_data,
  output logic [NUM_VC-1:0]        vc_active,
  output logic [NUM_VC-1:0]        credit,
  output logic [NUM_VC-1:0]        overflow,
  output logic [NUM_VC-1:0]        proto_err
);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int FLIT_W = DATA_W + 2;
  localparam logic [1:0] T_BODY = 2'b00;
  localparam logic [1:0] T_HEAD = 2'b01;
  localparam logic [1:0] T_TAIL = 2'b10;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic [FLIT_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  wp, rp;
    logic [CNT_W-1:0]  cnt;
    logic              act, ovf, err, crd;
    logic              sel, full, push, pop;

    assign sel  = in_valid && (in_vc == VC_W'(v));
    assign full = (cnt == CNT_W'(DEPTH));
    assign push = sel && !full;
    assign pop  = deq[v] && (cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
        act <= 1'b0;
        ovf <= 1'b0;
        err <= 1'b0;
        crd <= 1'b0;
      end else begin
        crd <= pop;
        cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
        if (sel && full) ovf <= 1'b1;
        if (push) begin
          wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
          if (!act && (in_type == T_BODY || in_type == T_TAIL)) err <= 1'b1;
          if (in_type == T_HEAD) act <= 1'b1;
          else if (in_type[1]) act <= 1'b0;
        end
        if (pop) rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (push) slots[wp] <= {in_type, in_data};
    end

    assign out_valid[v] = (cnt != '0);
    assign {out_type[2*v +: 2], out_data[v*DATA_W +: DATA_W]} = slots[rp];
    assign vc_active[v] = act;
    assign credit[v]    = crd;
    assign overflow[v]  = ovf;
    assign proto_err[v] = err;
  end
endmodule

// File: rtl/vc_input_port_chk.sv
module vc_input_port_chk #(
  parameter int NUM_VC = 2,
  parameter int DEPTH  = 3,
  parameter int DATA_W = 16,
  localparam int VC_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic [VC_W-1:0]          in_vc,
  input logic [1:0]               in_type,
  input logic [DATA_W-1:0]        in_data,
  input logic [NUM_VC-1:0]        deq,
  input logic [NUM_VC-1:0]        out_valid,
  input logic [2*NUM_VC-1:0]      out_type,
  input logic [DATA_W*NUM_VC-1:0] out_data,
  input logic [NUM_VC-1:0]        vc_active,
  input logic [NUM_VC-1:0]        credit,
  input logic [NUM_VC-1:0]        overflow,
  input logic [NUM_VC-1:0]        proto_err
);
  for (genvar v = 0; v < NUM_VC; v++) begin : g_a
    assert_credit_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      credit[v] |-> $past(deq[v] && out_valid[v]));
    assert_pop_gives_credit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (deq[v] && out_valid[v]) |=> credit[v]);
    assert_empty_pop_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (deq[v] && !out_valid[v]) |=> !credit[v]);
    assert_front_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[v] && !deq[v]) |=> (out_valid[v] && $stable(out_type[2*v +: 2])
                                     && $stable(out_data[v*DATA_W +: DATA_W])));
    assert_no_overflow_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      overflow[v] |=> overflow[v]);
    assert_overflow_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow[v]) |-> $past(in_valid && in_vc == VC_W'(v) && out_valid[v]));
    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err[v] |=> proto_err[v]);
    assert_active_needs_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vc_active[v]) |-> $past(in_valid && in_vc == VC_W'(v) && in_type == 2'b01));
  end
endmodule

bind vc_input_port vc_input_port_chk #(.NUM_VC(NUM_VC), .DEPTH(DEPTH), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc), .in_type(in_type),
  .in_data(in_data), .deq(deq), .out_valid(out_valid), .out_type(out_type),
  .out_data(out_data), .vc_active(vc_active), .credit(credit), .overflow(overflow),
  .proto_err(proto_err));

// File: tb/vc_input_port_tb_top.sv
module vc_input_port_tb_top;
  localparam int NV = 2, D = 3, DW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [0:0] in_vc = '0;
  logic [1:0] in_type = '0;
  logic [DW-1:0] in_data = '0;
  logic [NV-1:0] deq = '0;
  logic [NV-1:0] out_valid, vc_active, credit, overflow, proto_err;
  logic [2*NV-1:0] out_type;
  logic [DW*NV-1:0] out_data;

  vc_input_port #(.NUM_VC(NV), .DEPTH(D), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc), .in_type(in_type),
    .in_data(in_data), .deq(deq), .out_valid(out_valid), .out_type(out_type),
    .out_data(out_data), .vc_active(vc_active), .credit(credit), .overflow(overflow),
    .proto_err(proto_err));

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  string ph = "R8";
  int mt [NV][D];
  int md [NV][D];
  int mcnt [NV];
  bit mact [NV], merr [NV], movf [NV], mcrd [NV];
  logic [15:0] lf = 16'hACE1;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s (%s) actual=%0d expected=%0d", req, ph, act, exp);
    end
  endtask

  task automatic compare();
    for (int v = 0; v < NV; v++) begin
      check(out_valid[v] == (mcnt[v] > 0), "R1 valid", int'(out_valid[v]), int'(mcnt[v] > 0));
      if (mcnt[v] > 0) begin
        check(int'(out_type[2*v +: 2]) == mt[v][0], "R1 type", int'(out_type[2*v +: 2]), mt[v][0]);
        check(int'(out_data[v*DW +: DW]) == md[v][0], "R1 data", int'(out_data[v*DW +: DW]), md[v][0]);
      end
      check(vc_active[v] == mact[v], "R2 active", int'(vc_active[v]), int'(mact[v]));
      check(proto_err[v] == merr[v], "R3 err", int'(proto_err[v]), int'(merr[v]));
      check(overflow[v] == movf[v], "R4 overflow", int'(overflow[v]), int'(movf[v]));
      check(credit[v] == mcrd[v], "R6 credit", int'(credit[v]), int'(mcrd[v]));
    end
  endtask

  task automatic model_reset();
    for (int v = 0; v < NV; v++) begin
      mcnt[v] = 0; mact[v] = 0; merr[v] = 0; movf[v] = 0; mcrd[v] = 0;
    end
  endtask

  task automatic cyc(input bit iv, input int vc, input int ty, input int dat, input int dq);
    bit wr, full, push, pop;
    in_valid = iv; in_vc = 1'(vc); in_type = 2'(ty); in_data = DW'(dat); deq = NV'(dq);
    @(posedge clk);
    for (int v = 0; v < NV; v++) begin
      wr = iv && (vc == v);
      full = (mcnt[v] == D);
      push = wr && !full;
      pop = dq[v] && (mcnt[v] > 0);
      mcrd[v] = pop;
      if (wr && full) movf[v] = 1;
      if (push) begin
        if (!mact[v] && (ty == 0 || ty == 2)) merr[v] = 1;
        if (ty == 1) mact[v] = 1; else if (ty >= 2) mact[v] = 0;
      end
      if (pop) begin
        for (int i = 0; i < D - 1; i++) begin mt[v][i] = mt[v][i+1]; md[v][i] = md[v][i+1]; end
        mcnt[v]--;
      end
      if (push) begin mt[v][mcnt[v]] = ty; md[v][mcnt[v]] = dat & 8'hFF; mcnt[v]++; end
    end
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    in_valid = 0; deq = '0;
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    model_reset();
    rst_n = 1;
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    ph = "R8 reset";
    do_reset();
    ph = "R1 R2 R3 R6 type pairs";
    for (int v = 0; v < NV; v++)
      for (int t1 = 0; t1 < 4; t1++)
        for (int t2 = 0; t2 < 4; t2++) begin
          do_reset();
          cyc(1, v, t1, 16 * t1 + t2 + 1, 0);
          cyc(1, v, t2, 16 * t2 + t1 + 100, 0);
          cyc(0, 0, 0, 0, 1 << v);
          cyc(0, 0, 0, 0, 1 << v);
          cyc(0, 0, 0, 0, 0);
        end
    ph = "R4 R5 full queue";
    do_reset();
    cyc(1, 1, 1, 50, 0);
    cyc(1, 0, 1, 10, 0);
    cyc(1, 0, 0, 11, 0);
    cyc(1, 0, 0, 12, 0);
    cyc(1, 0, 2, 13, 2);
    cyc(1, 0, 2, 14, 1);
    cyc(1, 1, 0, 51, 1);
    cyc(1, 0, 2, 15, 2);
    cyc(0, 0, 0, 0, 3);
    ph = "R7 empty pop";
    cyc(0, 0, 0, 0, 3);
    cyc(0, 0, 0, 0, 3);
    cyc(0, 0, 0, 0, 3);
    ph = "R9 hold";
    cyc(1, 0, 3, 77, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 2);
    ph = "R10 write and pop";
    cyc(1, 0, 1, 78, 1);
    cyc(1, 0, 0, 79, 1);
    cyc(1, 0, 2, 80, 1);
    cyc(0, 0, 0, 0, 1);
    ph = "R1 R5 random";
    for (int r = 0; r < 4; r++) begin
      do_reset();
      for (int i = 0; i < 3000; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        cyc(lf[0] | lf[1], int'(lf[2]), int'(lf[4:3]), int'(lf[12:5]), int'(lf[14:13] & {lf[15], lf[11]}));
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule